// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory port. A cycle begins when one of two active-low start strobes is seen at a rising clock edge. One strobe is for the processor side and one is for the cache-controller side. On a start, the external address is captured and the selection state is decided from three chip-enable inputs. Once a burst is running, each cycle with the active-low advance input low and no strobe moves the low address bits to the next beat. A cycle with advance high holds the address where it is.

The low `BURST_W` bits follow one of two orders. The linear order adds the beat count to the captured low bits, modulo the burst length. The interleaved order XORs the beat count into the captured low bits. The order is taken from the mode input at the start of each burst, and the upper address bits do not change for the whole burst. Every input is registered by one clock edge, so `addr_out` and `sel` reflect the inputs sampled at the previous edge. The block has no handshake: it accepts a strobe on every cycle and has no back-pressure path. The mode input should be tied high when no choice is wired, which gives the interleaved order.

Top module: `bsq_burst_seq`

## Requirements
- R1: A start loads `addr_in` into the address register; one cycle later `addr_out` equals that address. A start is either `ads_proc_n` low while `ce_n` is low, or `ads_ctrl_n` low.
- R2: A processor-side start sets `sel` to (`ce2` high and `ce2_n` low). A controller-side start with `ce_n` low sets `sel` by the same rule.
- R3: When `ce_n` is high, a low `ads_proc_n` has no effect. With `ads_ctrl_n` and `adv_n` both high, `addr_out` and `sel` keep their values.
- R4: A controller-side start with `ce_n` high clears `sel`.
- R5: A burst started with `mode` low is linear. After k advances, the low two bits equal (start + k) mod 4.
- R6: A burst started with `mode` high is interleaved. After k advances, the low two bits equal start XOR (k mod 4).
- R7: Changing `mode` during a burst does not change the order in use. The order is fixed at the start.
- R8: When no start occurs and `adv_n` is high, `addr_out` and `sel` hold their values.
- R9: After four advances the address wraps back to the start address and keeps cycling.
- R10: `ce2` and `ce2_n` are sampled only on start cycles. Changing them on other cycles does not change `sel`.
- R11: A synchronous reset (`rst` high) leaves `sel` low and `addr_out` zero.
- R12: While `sel` is low, advance cycles leave `addr_out` unchanged.
- R13: The upper address bits change only on start cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_proc_n | input | 1 | Processor-side start strobe, active low, gated by `ce_n` |
| ads_ctrl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W (17) | External start address |
| addr_out | output | ADDR_W (17) | Current burst word address |
| sel | output | 1 | Device selected for the current burst |

## Verification
A wrong beat count or a wrong latched order shows on the low bits of `addr_out` at the first advance after the fault. Any error therefore appears within one cycle of the beat that went wrong, and it persists until the next start, because the sequence depends on the count. A wrong selection decision shows on `sel` one cycle after the start strobe. It cannot fix itself, because the enables are not looked at again until the next strobe. The bench sweeps every strobe and enable combination from a known selected state. It also runs every start value in both orders through two full wraps, with a suspend cycle and a mid-burst mode flip in each run.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned DEF_ADDR_W  = 17;
  localparam int unsigned DEF_BURST_W = 2;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_PROC = 2'd1,
    ST_CTRL = 2'd2
  } start_e;
endpackage

// File: rtl/bsq_start_decode.sv
module bsq_start_decode
  import bsq_pkg::*;
(
  input  logic   ads_proc_n,
  input  logic   ads_ctrl_n,
  input  logic   ce_n,
  input  logic   ce2,
  input  logic   ce2_n,
  output start_e kind,
  output logic   sel_next
);
  logic proc_ok;
  logic sec_ok;

  // the processor strobe is masked by the primary enable
  assign proc_ok = !ads_proc_n && !ce_n;
  assign sec_ok  = ce2 && !ce2_n;

  always_comb begin
    kind     = ST_NONE;
    sel_next = 1'b0;
    if (proc_ok) begin
      kind     = ST_PROC;
      sel_next = sec_ok;
    end else if (!ads_ctrl_n) begin
      kind     = ST_CTRL;
      sel_next = !ce_n && sec_ok;
    end
  end
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;  // wraps modulo 2**W
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] cnt,
  input  logic         interleave,
  output logic [W-1:0] low
);
  logic [W-1:0] lin;
  logic [W-1:0] ilv;

  assign lin = base + cnt;
  assign ilv = base ^ cnt;
  assign low = interleave ? ilv : lin;
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned BURST_W = DEF_BURST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce2_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  start_e              kind;
  logic                sel_next;
  logic                start;
  logic                step;
  logic [ADDR_W-1:0]   addr_q;
  logic                ilv_q;
  logic                sel_q;
  logic [BURST_W-1:0]  cnt;
  logic [BURST_W-1:0]  low;

  bsq_start_decode u_dec (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .ce_n       (ce_n),
    .ce2        (ce2),
    .ce2_n      (ce2_n),
    .kind       (kind),
    .sel_next   (sel_next)
  );

  assign start = (kind != ST_NONE);
  assign step  = !start && sel_q && !adv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
      ilv_q  <= 1'b1;
    end else if (start) begin
      addr_q <= addr_in;
      sel_q  <= sel_next;
      ilv_q  <= mode;
    end
  end

  bsq_beat_counter #(.W(BURST_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .step  (step),
    .cnt   (cnt)
  );

  bsq_order_map #(.W(BURST_W)) u_map (
    .base       (addr_q[BURST_W-1:0]),
    .cnt        (cnt),
    .interleave (ilv_q),
    .low        (low)
  );

  assign addr_out = {addr_q[ADDR_W-1 -: UP_W], low};
  assign sel      = sel_q;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ads_proc_n,
  input logic              ads_ctrl_n,
  input logic              adv_n,
  input logic              ce_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              sel
);
  logic go;
  assign go = (!ads_proc_n && !ce_n) || !ads_ctrl_n;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!sel && addr_out == '0)); // R11

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    go |=> (addr_out == $past(addr_in))); // R1

  AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (!ads_ctrl_n && ce_n) |=> !sel); // R4

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!go && adv_n) |=> ($stable(addr_out) && $stable(sel))); // R8

  AST_PROC_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && ce_n && ads_ctrl_n && adv_n) |=> ($stable(addr_out) && $stable(sel))); // R3

  AST_SEL_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(sel)); // R10

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(addr_out[ADDR_W-1:BURST_W])); // R13

  AST_DESEL_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!go && !sel) |=> $stable(addr_out)); // R12

  AST_ADVANCE_MOVES: assert property (@(posedge clk) disable iff (rst)
    (!go && sel && !adv_n) |=> (addr_out[BURST_W-1:0] != $past(addr_out[BURST_W-1:0]))); // R5
endmodule

bind bsq_burst_seq bsq_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .adv_n      (adv_n),
  .ce_n       (ce_n),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .sel        (sel)
);

// File: tb/tb_bsq_burst_seq.sv
`timescale 1ns/1ps
module tb_bsq_burst_seq;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
  logic ce_n = 1'b1, ce2 = 1'b0, ce2_n = 1'b1, mode = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic sel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bsq_burst_seq dut (
    .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .mode(mode),
    .addr_in(addr_in), .addr_out(addr_out), .sel(sel)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] exp_a, input logic exp_s);
    checks++;
    if (addr_out !== exp_a || sel !== exp_s) begin
      errors++;
      $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b", req, addr_out, sel, exp_a, exp_s);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic select_at(input logic [AW-1:0] a, input logic m);
    idle();
    ads_ctrl_n = 1'b0; ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
    addr_in = a; mode = m;
    step();
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] a0, b0, exp_a, x;
    logic exp_s;
    @(negedge clk);
    step();
    step();
    chk("R11 reset", '0, 1'b0);
    rst = 1'b0;
    step();
    chk("R11 after reset idle", '0, 1'b0);

    // strobe and enable sweep: R1 R2 R3 R4 R10
    for (int v = 0; v < 32; v++) begin
      a0 = 17'h0A5A4 + AW'(v);
      b0 = 17'h15003 ^ AW'(v * 37);
      select_at(a0, 1'b0);
      ads_proc_n = v[0]; ads_ctrl_n = v[1]; ce_n = v[2]; ce2 = v[3]; ce2_n = v[4];
      adv_n = 1'b1; addr_in = b0;
      step();
      if (!v[0] && !v[2]) begin
        exp_a = b0; exp_s = v[3] && !v[4];
      end else if (!v[1]) begin
        exp_a = b0; exp_s = !v[2] && v[3] && !v[4];
      end else begin
        exp_a = a0; exp_s = 1'b1;
      end
      chk("R1 R2 R3 R4 R10 strobe/enable combo", exp_a, exp_s);
      idle();
    end

    // burst order sweep: R5 R6 R7 R8 R9 R13
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 4; b++) begin
        a0 = {15'h5A3C ^ 15'(b * 911 + m), 2'(b)};
        idle();
        ads_proc_n = 1'b0; ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
        addr_in = a0; mode = m[0];
        step();
        chk("R1 burst start", a0, 1'b1);
        idle();
        mode = !m[0];                     // R7: flip mid-burst
        for (int k = 1; k <= 8; k++) begin
          if (k == 3) begin
            adv_n = 1'b1; ce2 = 1'b0;      // R8 suspend, R10 no resample
            step();
            checks++;
            if (addr_out[AW-1:2] !== a0[AW-1:2] || sel !== 1'b1) begin
              errors++;
              $display("FAIL R8 suspend: addr=%h sel=%b expected upper=%h sel=1", addr_out, sel, a0[AW-1:2]);
            end
          end
          adv_n = 1'b0;
          addr_in = ~a0;
          step();
          exp_a = a0;
          exp_a[1:0] = (m == 0) ? 2'(b + k) : (2'(b) ^ 2'(k));
          chk(m == 0 ? "R5 R7 R9 R13 linear beat" : "R6 R7 R9 R13 interleaved beat", exp_a, 1'b1);
        end
        idle();
        ce2 = 1'b1;
      end
    end

    // deselected hold: R12, R4, R10
    x = 17'h1F0F2;
    idle();
    ads_ctrl_n = 1'b0; ce_n = 1'b1; addr_in = x;
    step();
    chk("R4 controller deselect", x, 1'b0);
    idle();
    ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      adv_n = 1'b0;
      step();
      chk("R12 R10 no step while deselected", x, 1'b0);
    end

    // reset mid-burst: R11
    select_at(17'h0ABCD, 1'b1);
    adv_n = 1'b0;
    step();
    rst = 1'b1;
    step();
    chk("R11 reset mid-burst", '0, 1'b0);
    rst = 1'b0;
    step();
    chk("R11 stays clear", '0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule